// File: doc/BRIEF.md
# Receive frame length limiter

This block sits between an infrared deframer and the receive FIFO. The deframer presents data bytes one at a time and marks the start of each frame with a one-cycle strobe. The block counts the bytes of the current frame with a 13-bit up-counter and checks each incoming byte against a programmed maximum receive length. Bytes within the limit pass on to the FIFO write port. The first byte that would take the frame past the limit is dropped and raises a sticky length-exceeded flag. Every later byte of that frame is dropped as well, and forwarding resumes at the next frame start.

The limit is split across two inputs: an 8-bit low part and a 5-bit high part. The live byte count of the current frame is always visible on an output, so software can read how much of a frame has arrived. Enforcement only applies while the automatic packet mode enable is high. With the enable low, every byte is forwarded and the flag stays untouched.

Top module: `rx_len_limiter`

## Requirements
- R1: After synchronous reset the byte count is 0, the length-exceeded flag is 0 and no FIFO write is issued.
- R2: The limit is the 13-bit value whose bits 7:0 come from `max_len_lo` and whose bits 12:8 come from `max_len_hi`.
- R3: Each cycle with `rx_valid` high adds one to `rx_count`, visible on the cycle after the byte is presented.
- R4: A `sof` strobe restarts the count at zero; a byte presented in the same cycle as `sof` is the first byte of the new frame (count becomes 1).
- R5: With the mode enabled, bytes numbered 1 through the limit are forwarded: `fifo_wr` is high and `fifo_data` holds the byte on the cycle after it is presented.
- R6: With the mode enabled, the byte numbered limit+1 is not forwarded, and the flag is 1 on the following cycle.
- R7: After an overrun, every further byte of the frame is dropped until `sof`; the byte arriving with `sof` and those after it are forwarded again within the limit.
- R8: The flag is sticky across frame starts, clears on a `stat_rd` pulse, and is set by any byte dropped for length, which wins over a `stat_rd` in the same cycle.
- R9: The count saturates at 8191 and never wraps back to zero within a frame.
- R10: With the mode disabled, every byte is forwarded and the flag is never set, whatever the count and limit.
- R11: With the mode enabled and a limit of 0, every byte is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Automatic packet mode enable; limiting is active when high |
| max_len_lo | input | 8 | Limit bits 7:0 |
| max_len_hi | input | 5 | Limit bits 12:8 |
| sof | input | 1 | Start-of-frame strobe from the deframer |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| stat_rd | input | 1 | Status read strobe; clears the length-exceeded flag |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Byte to write into the receive FIFO |
| rx_count | output | 13 | Bytes received so far in the current frame |
| len_exceeded | output | 1 | Sticky maximum-length-exceeded flag |

## Verification
The bench targets the boundary byte. A frame of exactly the limit must forward every byte, and the next byte must be dropped. An off-by-one compare would either lose the last legal byte or let one extra byte into the FIFO. It also drives limits whose high part is non-zero, which catches swapped or truncated limit halves. It sends a byte together with `sof` to make sure the new frame is counted from one and that discard is lifted at that point rather than a cycle late. A run of more than 8191 bytes with the mode off checks that the count saturates instead of wrapping, and that the flag stays clear. Random frames mix `stat_rd` with dropped bytes, so a design where the clear beats a simultaneous set shows up as a missing flag.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  localparam int CNT_W_DEF  = 13;
  localparam int DATA_W_DEF = 8;
  localparam int LO_W_DEF   = 8;
endpackage

// File: rtl/rfl_counter.sv
module rfl_counter #(
  parameter int CNT_W = rfl_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             inc,
  output logic [CNT_W:0]   arrive_num,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base;

  always_comb begin
    base       = sof ? '0 : cnt;
    arrive_num = {1'b0, base} + {{CNT_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= arrive_num[CNT_W] ? CNT_MAX : arrive_num[CNT_W-1:0];
    end else if (sof) begin
      cnt <= '0;
    end
  end

  // R4
  sof_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sof && !inc) |=> (cnt == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !sof && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  // R9
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !sof && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/rfl_gate.sv
module rfl_gate #(
  parameter int CNT_W = rfl_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic             sof,
  input  logic             rx_valid,
  input  logic             stat_rd,
  input  logic [CNT_W:0]   arrive_num,
  input  logic [CNT_W-1:0] limit,
  output logic             drop,
  output logic             len_exceeded
);
  logic disc_q;
  logic disc_base;
  logic over;

  always_comb begin
    disc_base = sof ? 1'b0 : disc_q;
    over      = arrive_num > {1'b0, limit};
    drop      = rx_valid && mode_en && (disc_base || over);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disc_q       <= 1'b0;
      len_exceeded <= 1'b0;
    end else begin
      disc_q <= disc_base || drop;
      if (drop) begin
        len_exceeded <= 1'b1;
      end else if (stat_rd) begin
        len_exceeded <= 1'b0;
      end
    end
  end

  // R7
  discard_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (drop && !stat_rd) |=> (len_exceeded && disc_q));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (len_exceeded && !stat_rd) |=> len_exceeded);
endmodule

// File: rtl/rfl_out.sv
module rfl_out #(
  parameter int DATA_W = rfl_pkg::DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              drop,
  input  logic [DATA_W-1:0] rx_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= rx_valid && !drop;
      if (rx_valid) begin
        fifo_data <= rx_data;
      end
    end
  end

  // R5
  no_spurious_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !fifo_wr);
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter #(
  parameter int CNT_W  = rfl_pkg::CNT_W_DEF,
  parameter int DATA_W = rfl_pkg::DATA_W_DEF,
  parameter int LO_W   = rfl_pkg::LO_W_DEF,
  localparam int HI_W  = CNT_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic [LO_W-1:0]   max_len_lo,
  input  logic [HI_W-1:0]   max_len_hi,
  input  logic              sof,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              stat_rd,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic [CNT_W-1:0]  rx_count,
  output logic              len_exceeded
);
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   arrive_num;
  logic             drop;

  assign limit = {max_len_hi, max_len_lo};

  rfl_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .sof(sof), .inc(rx_valid),
    .arrive_num(arrive_num), .cnt(rx_count)
  );

  rfl_gate #(.CNT_W(CNT_W)) i_gate (
    .clk(clk), .rst(rst), .mode_en(mode_en), .sof(sof),
    .rx_valid(rx_valid), .stat_rd(stat_rd), .arrive_num(arrive_num),
    .limit(limit), .drop(drop), .len_exceeded(len_exceeded)
  );

  rfl_out #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .drop(drop),
    .rx_data(rx_data), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );

  // R6
  boundary_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && rx_valid && !sof && rx_count == limit) |=> (!fifo_wr && len_exceeded));

  // R10
  mode_off_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_en && rx_valid) |=> fifo_wr);

  // R10
  mode_off_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_en && !len_exceeded) |=> !len_exceeded);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_valid) |=> !len_exceeded);
endmodule

// File: tb/test_rx_len_limiter.sv
module test_rx_len_limiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_en = 1'b0;
  logic [7:0]  max_len_lo = '0;
  logic [4:0]  max_len_hi = '0;
  logic        sof = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        stat_rd = 1'b0;
  logic        fifo_wr;
  logic [7:0]  fifo_data;
  logic [12:0] rx_count;
  logic        len_exceeded;

  int checks = 0;
  int errors = 0;

  int m_cnt = 0;
  bit m_disc = 0;
  bit m_flag = 0;
  bit e_wr = 0;
  logic [7:0] e_data = '0;

  always #5 clk = ~clk;

  rx_len_limiter i_rx_len_limiter (
    .clk(clk), .rst(rst), .mode_en(mode_en), .max_len_lo(max_len_lo),
    .max_len_hi(max_len_hi), .sof(sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .stat_rd(stat_rd), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .rx_count(rx_count), .len_exceeded(len_exceeded)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim_val();
    return {max_len_hi, max_len_lo};
  endfunction

  task automatic set_lim(input int v);
    max_len_lo = v[7:0];
    max_len_hi = v[12:8];
  endtask

  task automatic step(input bit s, input bit v, input bit rd);
    int base, num;
    bit dbase, drp;
    @(negedge clk);
    sof = s; rx_valid = v; stat_rd = rd; rx_data = 8'($urandom);
    @(posedge clk);
    base  = s ? 0 : m_cnt;
    dbase = s ? 1'b0 : m_disc;
    num   = base + 1;
    drp   = v && mode_en && (dbase || num > lim_val());
    m_disc = dbase || drp;
    if (v) m_cnt = (num > 8191) ? 8191 : num;
    else   m_cnt = base;
    if (drp) m_flag = 1;
    else if (rd) m_flag = 0;
    e_wr = v && !drp;
    if (v) e_data = rx_data;
    #2;
    chk("R3 count", rx_count, m_cnt);
    chk("R5 write", fifo_wr, e_wr);
    if (e_wr) chk("R5 data", fifo_data, e_data);
    chk("R8 flag", len_exceeded, m_flag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 count", rx_count, 0);
    chk("R1 flag", len_exceeded, 0);
    chk("R1 write", fifo_wr, 0);
    @(negedge clk);
    rst = 1'b0;

    // R5 R6 R7: limit 4, frame of 6 bytes, then new frame with byte on sof
    mode_en = 1'b1;
    set_lim(4);
    step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    chk("R5 last legal byte", fifo_wr, 1);
    step(0, 1, 0);
    chk("R6 overrun byte dropped", fifo_wr, 0);
    chk("R6 flag set", len_exceeded, 1);
    step(0, 0, 0);
    step(0, 1, 0);
    chk("R7 still dropping", fifo_wr, 0);
    step(1, 1, 0);
    chk("R4 byte with sof counts one", rx_count, 1);
    chk("R7 forwarding resumes", fifo_wr, 1);
    chk("R8 flag sticky across sof", len_exceeded, 1);
    step(0, 0, 1);
    chk("R8 flag cleared by read", len_exceeded, 0);

    // R8 set wins over simultaneous read
    step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0);
    step(0, 1, 1);
    chk("R8 set beats clear", len_exceeded, 1);
    step(0, 0, 1);

    // R2 limit with high bits: 261
    set_lim(261);
    step(1, 0, 0);
    for (int i = 0; i < 261; i++) step(0, 1, 0);
    chk("R2 byte 261 forwarded", fifo_wr, 1);
    step(0, 1, 0);
    chk("R2 byte 262 dropped", fifo_wr, 0);
    chk("R2 count", rx_count, 262);
    step(0, 0, 1);

    // R11 limit zero
    set_lim(0);
    step(1, 1, 0);
    chk("R11 first byte dropped", fifo_wr, 0);
    step(0, 1, 0);
    chk("R11 second byte dropped", fifo_wr, 0);
    step(0, 0, 1);

    // R10 R9 mode off, long frame saturates
    mode_en = 1'b0;
    set_lim(3);
    step(1, 0, 0);
    for (int i = 0; i < 8195; i++) step(0, 1, 0);
    chk("R9 count saturated", rx_count, 8191);
    chk("R10 forwarded past limit", fifo_wr, 1);
    chk("R10 flag never set", len_exceeded, 0);
    step(1, 0, 0);
    chk("R4 sof clears count", rx_count, 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 64) == 0) begin
        mode_en = ($urandom % 4) != 0;
        set_lim(($urandom % 2) ? int'($urandom % 12) : int'($urandom % 300));
      end
      step(($urandom % 24) == 0, ($urandom % 4) != 0, ($urandom % 16) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule